// File: doc/BRIEF.md
# Fractional PLL Output Frequency Calculator

This block works out the output frequency of a phase-locked loop from the frequency of its parent clock and the divider settings held for that loop. It supports two loop styles. In the fractional style the settings are a feedback multiplier, an input divider, a 24-bit fraction, an integer-mode flag and two output dividers. In the legacy style the settings are three divider codes, each stored as its value minus one, plus a bypass flag.

A request is a one-cycle `start` pulse. All operands are captured on that edge. The result then comes out on `freq_out` together with a one-cycle `done` pulse. The arithmetic runs over several clock cycles. One registered multiplier and one restoring shift-subtract divider, which produces one quotient bit per cycle, are used again for each step. Every division truncates, and the divisions run in a fixed order, so the result matches software that does the same integer sequence.

Top module: `pll_freq_calc`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy`, `done`, `err` and `freq_out` are all 0.
- R2: In the fractional style (`style`=0) with `int_mode`=1, the result is ((parent×fb)/ref)/pa)/pb. Every division truncates. `frac_val` has no effect.
- R3: In the fractional style with `int_mode`=0, the term ((parent×frac)/ref)>>24 is added to (parent×fb)/ref. The sum is then divided by pa and then by pb, truncating each time. `frac_val` is 24 bits wide.
- R4: In the legacy style (`style`=1) with `bypass`=0, the result is ((parent×(nf+1))/(nr+1))/(no+1), truncating at each step. Here nf, nr and no are the raw codes.
- R5: In the legacy style with `bypass`=1, `done` rises on the cycle after the accepted start. At that point `freq_out` equals the parent frequency and `err` is 0.
- R6: In the fractional style, if `ref_div`, `post_div_a` or `post_div_b` is zero, `done` rises on the cycle after the accepted start with `freq_out`=0 and `err`=1. Any completed calculation without such a zero clears `err`.
- R7: A `start` that arrives while `busy` is high is ignored. It does not change the result in progress and does not cause a second `done`. Operands are sampled only when a start is accepted.
- R8: `done` lasts exactly one cycle and is never high together with `busy`. `busy` is high from the cycle after an accepted full calculation until `done`. `freq_out` changes only on the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when not busy |
| style | input | 1 | 0 = fractional style, 1 = legacy style |
| parent_hz | input | 32 | Parent clock frequency |
| fb_div | input | 12 | Feedback multiplier (fractional style) |
| ref_div | input | 6 | Input divider (fractional style) |
| post_div_a | input | 3 | First output divider (fractional style) |
| post_div_b | input | 3 | Second output divider (fractional style) |
| frac_val | input | 24 | Fraction, scaled by 2^24 |
| int_mode | input | 1 | 1 = integer mode, fraction ignored |
| nr_code | input | 6 | Legacy input divider minus one |
| no_code | input | 4 | Legacy output divider minus one |
| nf_code | input | 13 | Legacy feedback multiplier minus one |
| bypass | input | 1 | Legacy bypass, output follows parent |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last result came from a zero divisor |
| freq_out | output | 64 | Computed frequency |

## Verification
A wrong step order or a lost truncation shows up only in the value on `freq_out`, and only at the `done` strobe. That strobe comes one cycle after start for the shortcut paths and a few hundred cycles later for the full paths. The expected values are computed in the bench with 64-bit integer arithmetic, so a sequencer that skips the fraction step or uses a stale operand fails on the first affected request. A sequencer that hangs or restarts shows up as a missing or repeated `done` within a bounded wait.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_MUL_INT = 4'd1,
    ST_DIV_REF = 4'd2,
    ST_MUL_FRC = 4'd3,
    ST_DIV_FRC = 4'd4,
    ST_DIV_PA  = 4'd5,
    ST_DIV_PB  = 4'd6,
    ST_DIV_NO  = 4'd7
  } calc_state_e;

endpackage

// File: rtl/pll_calc_mul.sv
module pll_calc_mul #(
  parameter int A_W = 32,
  parameter int B_W = 24,
  parameter int P_W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [A_W-1:0] op_a,
  input  logic [B_W-1:0] op_b,
  output logic [P_W-1:0] prod
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prod <= '0;
    end else if (go) begin
      prod <= P_W'(op_a) * P_W'(op_b);
    end
  end

endmodule

// File: rtl/pll_calc_div.sv
module pll_calc_div #(
  parameter int N_W = 64,
  parameter int D_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic [N_W-1:0] quotient,
  output logic           fin
);

  localparam int CNT_W = $clog2(N_W);

  logic [N_W-1:0]   quo_q;
  logic [D_W-1:0]   rem_q;
  logic [D_W-1:0]   dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [D_W:0]     trial;
  logic [D_W:0]     diff;
  logic             take;

  assign trial = {rem_q, quo_q[N_W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign take  = (trial >= {1'b0, dvs_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else if (go) begin
      quo_q <= dividend;
      rem_q <= '0;
      dvs_q <= divisor;
      cnt_q <= '0;
      run_q <= 1'b1;
      fin   <= 1'b0;
    end else if (run_q) begin
      rem_q <= take ? diff[D_W-1:0] : trial[D_W-1:0];
      quo_q <= {quo_q[N_W-2:0], take};
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(N_W - 1)) begin
        run_q <= 1'b0;
        fin   <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign quotient = quo_q;

endmodule

// File: rtl/pll_calc_seq.sv
module pll_calc_seq
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int FB_W   = 12,
  parameter int REF_W  = 6,
  parameter int PD_W   = 3,
  parameter int FRAC_W = 24,
  parameter int NR_W   = 6,
  parameter int NO_W   = 4,
  parameter int NF_W   = 13,
  parameter int ACC_W  = 64,
  parameter int MB_W   = 24,
  parameter int DV_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              style,
  input  logic [FREQ_W-1:0] parent_hz,
  input  logic [FB_W-1:0]   fb_div,
  input  logic [REF_W-1:0]  ref_div,
  input  logic [PD_W-1:0]   post_div_a,
  input  logic [PD_W-1:0]   post_div_b,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic              int_mode,
  input  logic [NR_W-1:0]   nr_code,
  input  logic [NO_W-1:0]   no_code,
  input  logic [NF_W-1:0]   nf_code,
  input  logic              bypass,
  output logic              mul_go,
  output logic [FREQ_W-1:0] mul_a,
  output logic [MB_W-1:0]   mul_b,
  input  logic [ACC_W-1:0]  mul_p,
  output logic              div_go,
  output logic [ACC_W-1:0]  div_n,
  output logic [DV_W-1:0]   div_d,
  input  logic [ACC_W-1:0]  div_q,
  input  logic              div_fin,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ACC_W-1:0]  freq_out
);

  calc_state_e       state_q;
  logic [FREQ_W-1:0] l_parent;
  logic [REF_W-1:0]  l_ref;
  logic [PD_W-1:0]   l_pa;
  logic [PD_W-1:0]   l_pb;
  logic [FRAC_W-1:0] l_frac;
  logic              l_int;
  logic              l_legacy;
  logic [NR_W-1:0]   l_nr;
  logic [NO_W-1:0]   l_no;
  logic [ACC_W-1:0]  acc_q;

  logic accept, take_bypass, take_zero;

  assign accept      = start && (state_q == ST_IDLE);
  assign take_bypass = style && bypass;
  assign take_zero   = !style && ((ref_div == '0) || (post_div_a == '0) || (post_div_b == '0));

  always_comb begin
    mul_go = 1'b0;
    mul_a  = l_parent;
    mul_b  = '0;
    div_go = 1'b0;
    div_n  = div_q;
    div_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && !take_bypass && !take_zero) begin
          mul_go = 1'b1;
          mul_a  = parent_hz;
          mul_b  = style ? (MB_W'(nf_code) + MB_W'(1)) : MB_W'(fb_div);
        end
      end
      ST_MUL_INT: begin
        div_go = 1'b1;
        div_n  = mul_p;
        div_d  = l_legacy ? (DV_W'(l_nr) + DV_W'(1)) : DV_W'(l_ref);
      end
      ST_DIV_REF: begin
        if (div_fin) begin
          if (l_legacy) begin
            div_go = 1'b1;
            div_d  = DV_W'(l_no) + DV_W'(1);
          end else if (!l_int) begin
            mul_go = 1'b1;
            mul_b  = MB_W'(l_frac);
          end else begin
            div_go = 1'b1;
            div_d  = DV_W'(l_pa);
          end
        end
      end
      ST_MUL_FRC: begin
        div_go = 1'b1;
        div_n  = mul_p;
        div_d  = DV_W'(l_ref);
      end
      ST_DIV_FRC: begin
        if (div_fin) begin
          div_go = 1'b1;
          div_n  = acc_q + (div_q >> FRAC_W);
          div_d  = DV_W'(l_pa);
        end
      end
      ST_DIV_PA: begin
        if (div_fin) begin
          div_go = 1'b1;
          div_d  = DV_W'(l_pb);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      l_parent <= '0;
      l_ref    <= '0;
      l_pa     <= '0;
      l_pb     <= '0;
      l_frac   <= '0;
      l_int    <= 1'b0;
      l_legacy <= 1'b0;
      l_nr     <= '0;
      l_no     <= '0;
      acc_q    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      freq_out <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            l_parent <= parent_hz;
            l_ref    <= ref_div;
            l_pa     <= post_div_a;
            l_pb     <= post_div_b;
            l_frac   <= frac_val;
            l_int    <= int_mode;
            l_legacy <= style;
            l_nr     <= nr_code;
            l_no     <= no_code;
            if (take_bypass) begin
              freq_out <= ACC_W'(parent_hz);
              err      <= 1'b0;
              done     <= 1'b1;
            end else if (take_zero) begin
              freq_out <= '0;
              err      <= 1'b1;
              done     <= 1'b1;
            end else begin
              state_q <= ST_MUL_INT;
            end
          end
        end
        ST_MUL_INT: state_q <= ST_DIV_REF;
        ST_DIV_REF: begin
          if (div_fin) begin
            if (l_legacy) begin
              state_q <= ST_DIV_NO;
            end else if (!l_int) begin
              acc_q   <= div_q;
              state_q <= ST_MUL_FRC;
            end else begin
              state_q <= ST_DIV_PA;
            end
          end
        end
        ST_MUL_FRC: state_q <= ST_DIV_FRC;
        ST_DIV_FRC: if (div_fin) state_q <= ST_DIV_PA;
        ST_DIV_PA:  if (div_fin) state_q <= ST_DIV_PB;
        ST_DIV_PB, ST_DIV_NO: begin
          if (div_fin) begin
            freq_out <= div_q;
            err      <= 1'b0;
            done     <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc #(
  parameter int FREQ_W = 32,
  parameter int FB_W   = 12,
  parameter int REF_W  = 6,
  parameter int PD_W   = 3,
  parameter int FRAC_W = 24,
  parameter int NR_W   = 6,
  parameter int NO_W   = 4,
  parameter int NF_W   = 13,
  parameter int ACC_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              style,
  input  logic [FREQ_W-1:0] parent_hz,
  input  logic [FB_W-1:0]   fb_div,
  input  logic [REF_W-1:0]  ref_div,
  input  logic [PD_W-1:0]   post_div_a,
  input  logic [PD_W-1:0]   post_div_b,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic              int_mode,
  input  logic [NR_W-1:0]   nr_code,
  input  logic [NO_W-1:0]   no_code,
  input  logic [NF_W-1:0]   nf_code,
  input  logic              bypass,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ACC_W-1:0]  freq_out
);

  localparam int MB_A = (FB_W > FRAC_W) ? FB_W : FRAC_W;
  localparam int MB_W = (MB_A > NF_W + 1) ? MB_A : NF_W + 1;
  localparam int DV_A = (REF_W > PD_W) ? REF_W : PD_W;
  localparam int DV_B = (NR_W > NO_W) ? NR_W + 1 : NO_W + 1;
  localparam int DV_W = (DV_A > DV_B) ? DV_A : DV_B;

  logic              mul_go;
  logic [FREQ_W-1:0] mul_a;
  logic [MB_W-1:0]   mul_b;
  logic [ACC_W-1:0]  mul_p;
  logic              div_go;
  logic [ACC_W-1:0]  div_n;
  logic [DV_W-1:0]   div_d;
  logic [ACC_W-1:0]  div_q;
  logic              div_fin;

  pll_calc_mul #(.A_W(FREQ_W), .B_W(MB_W), .P_W(ACC_W)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .op_a(mul_a), .op_b(mul_b), .prod(mul_p)
  );

  pll_calc_div #(.N_W(ACC_W), .D_W(DV_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .dividend(div_n), .divisor(div_d),
    .quotient(div_q), .fin(div_fin)
  );

  pll_calc_seq #(
    .FREQ_W(FREQ_W), .FB_W(FB_W), .REF_W(REF_W), .PD_W(PD_W), .FRAC_W(FRAC_W),
    .NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W), .ACC_W(ACC_W), .MB_W(MB_W), .DV_W(DV_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .style(style), .parent_hz(parent_hz),
    .fb_div(fb_div), .ref_div(ref_div), .post_div_a(post_div_a), .post_div_b(post_div_b),
    .frac_val(frac_val), .int_mode(int_mode), .nr_code(nr_code), .no_code(no_code),
    .nf_code(nf_code), .bypass(bypass),
    .mul_go(mul_go), .mul_a(mul_a), .mul_b(mul_b), .mul_p(mul_p),
    .div_go(div_go), .div_n(div_n), .div_d(div_d), .div_q(div_q), .div_fin(div_fin),
    .busy(busy), .done(done), .err(err), .freq_out(freq_out)
  );

endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk #(
  parameter int FREQ_W = 32,
  parameter int REF_W  = 6,
  parameter int PD_W   = 3,
  parameter int ACC_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              style,
  input logic              bypass,
  input logic [FREQ_W-1:0] parent_hz,
  input logic [REF_W-1:0]  ref_div,
  input logic [PD_W-1:0]   post_div_a,
  input logic [PD_W-1:0]   post_div_b,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [ACC_W-1:0]  freq_out
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !err && (freq_out == '0)));

  assert_bypass_path_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && style && bypass) |=>
      (done && !err && (freq_out == ACC_W'($past(parent_hz)))));

  assert_zero_divisor_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !style &&
     ((ref_div == '0) || (post_div_a == '0) || (post_div_b == '0))) |=>
      (done && err && (freq_out == '0)));

  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_result_moves_on_done_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_out) |-> done);

endmodule

bind pll_freq_calc pll_freq_calc_chk #(
  .FREQ_W(FREQ_W), .REF_W(REF_W), .PD_W(PD_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .style(style), .bypass(bypass),
  .parent_hz(parent_hz), .ref_div(ref_div), .post_div_a(post_div_a),
  .post_div_b(post_div_b), .busy(busy), .done(done), .err(err), .freq_out(freq_out)
);

// File: tb/pll_freq_calc_test.sv
`timescale 1ns/1ps
module pll_freq_calc_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        style = 1'b0;
  logic [31:0] parent_hz = '0;
  logic [11:0] fb_div = '0;
  logic [5:0]  ref_div = '0;
  logic [2:0]  post_div_a = '0;
  logic [2:0]  post_div_b = '0;
  logic [23:0] frac_val = '0;
  logic        int_mode = 1'b1;
  logic [5:0]  nr_code = '0;
  logic [3:0]  no_code = '0;
  logic [12:0] nf_code = '0;
  logic        bypass = 1'b0;
  logic        busy, done, err;
  logic [63:0] freq_out;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pll_freq_calc uut (
    .clk(clk), .rst(rst), .start(start), .style(style), .parent_hz(parent_hz),
    .fb_div(fb_div), .ref_div(ref_div), .post_div_a(post_div_a), .post_div_b(post_div_b),
    .frac_val(frac_val), .int_mode(int_mode), .nr_code(nr_code), .no_code(no_code),
    .nf_code(nf_code), .bypass(bypass), .busy(busy), .done(done), .err(err),
    .freq_out(freq_out)
  );

  function automatic logic [63:0] model_frac(logic [31:0] p, logic [11:0] fb, logic [5:0] rf,
                                             logic [2:0] da, logic [2:0] db, logic [23:0] fr,
                                             logic im);
    logic [63:0] a;
    if (rf == 0 || da == 0 || db == 0) return 64'd0;
    a = (64'(p) * 64'(fb)) / 64'(rf);
    if (!im) a = a + (((64'(p) * 64'(fr)) / 64'(rf)) >> 24);
    a = a / 64'(da);
    a = a / 64'(db);
    return a;
  endfunction

  function automatic logic [63:0] model_leg(logic [31:0] p, logic [12:0] nf, logic [5:0] nr,
                                            logic [3:0] no, logic bp);
    logic [63:0] a;
    if (bp) return 64'(p);
    a = (64'(p) * (64'(nf) + 64'd1)) / (64'(nr) + 64'd1);
    return a / (64'(no) + 64'd1);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic [63:0] r, output logic e);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R8 actual=no_done expected=done");
    end
    r = freq_out;
    e = err;
    @(negedge clk);
    check("R8 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic set_frac(logic [31:0] p, logic [11:0] fb, logic [5:0] rf, logic [2:0] da,
                          logic [2:0] db, logic [23:0] fr, logic im);
    style = 1'b0; parent_hz = p; fb_div = fb; ref_div = rf;
    post_div_a = da; post_div_b = db; frac_val = fr; int_mode = im;
  endtask

  task automatic set_leg(logic [31:0] p, logic [12:0] nf, logic [5:0] nr, logic [3:0] no,
                         logic bp);
    style = 1'b1; parent_hz = p; nf_code = nf; nr_code = nr; no_code = no; bypass = bp;
  endtask

  task automatic run_frac(string req, logic [31:0] p, logic [11:0] fb, logic [5:0] rf,
                          logic [2:0] da, logic [2:0] db, logic [23:0] fr, logic im);
    logic [63:0] r;
    logic e;
    logic zero;
    zero = (rf == 0 || da == 0 || db == 0);
    set_frac(p, fb, rf, da, db, fr, im);
    launch();
    wait_done(r, e);
    check(req, r, model_frac(p, fb, rf, da, db, fr, im));
    check({req, " err"}, 64'(e), 64'(zero));
  endtask

  task automatic run_leg(string req, logic [31:0] p, logic [12:0] nf, logic [5:0] nr,
                         logic [3:0] no, logic bp);
    logic [63:0] r;
    logic e;
    set_leg(p, nf, nr, no, bp);
    launch();
    wait_done(r, e);
    check(req, r, model_leg(p, nf, nr, no, bp));
    check({req, " err"}, 64'(e), 64'd0);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] r;
    logic e;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 err", 64'(err), 64'd0);
    check("R1 freq_out", freq_out, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {61'd0, busy, done, err}, 64'd0);

    // R2 directed: fraction nonzero but ignored in integer mode
    run_frac("R2 integer", 32'd24000000, 12'd100, 6'd1, 3'd2, 3'd1, 24'hABCDEF, 1'b1);
    run_frac("R2 integer max", 32'hFFFFFFFF, 12'hFFF, 6'd1, 3'd1, 3'd1, 24'd0, 1'b1);
    // R3 directed: half fraction truncated separately (3/2=1, frac term 0)
    run_frac("R3 frac trunc", 32'd3, 12'd1, 6'd2, 3'd1, 3'd1, 24'h800000, 1'b0);
    run_frac("R3 frac full", 32'd24000000, 12'd50, 6'd3, 3'd1, 3'd1, 24'hFFFFFF, 1'b0);
    // R4 directed: all codes zero means all dividers one
    run_leg("R4 legacy", 32'd24000000, 13'd49, 6'd0, 4'd1, 1'b0);
    run_leg("R4 legacy min", 32'd1000, 13'd0, 6'd0, 4'd0, 1'b0);
    // R5 bypass with one-cycle latency
    set_leg(32'd12345678, 13'd99, 6'd3, 4'd2, 1'b1);
    launch();
    check("R5 bypass done", 64'(done), 64'd1);
    check("R5 bypass value", freq_out, 64'd12345678);
    check("R5 bypass err", 64'(err), 64'd0);
    @(negedge clk);
    bypass = 1'b0;
    // R6 zero divisors
    set_frac(32'd24000000, 12'd100, 6'd0, 3'd1, 3'd1, 24'd0, 1'b1);
    launch();
    check("R6 zero ref done", 64'(done), 64'd1);
    check("R6 zero ref value", freq_out, 64'd0);
    check("R6 zero ref err", 64'(err), 64'd1);
    run_frac("R6 zero pb", 32'd24000000, 12'd100, 6'd1, 3'd1, 3'd0, 24'd0, 1'b1);
    run_frac("R6 err clears", 32'd24000000, 12'd10, 6'd1, 3'd1, 3'd1, 24'd0, 1'b1);

    // R7: start while busy is ignored; R8 busy after accepted start
    set_frac(32'd50000000, 12'd40, 6'd2, 3'd2, 3'd1, 24'h123456, 1'b0);
    launch();
    check("R8 busy", 64'(busy), 64'd1);
    repeat (20) @(negedge clk);
    set_frac(32'd7, 12'd3, 6'd1, 3'd1, 3'd1, 24'd0, 1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(r, e);
    check("R7 first result kept", r,
          model_frac(32'd50000000, 12'd40, 6'd2, 3'd2, 3'd1, 24'h123456, 1'b0));
    begin
      int extra = 0;
      for (int i = 0; i < 500; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R7 no second done", 64'(extra), 64'd0);
    end

    for (int i = 0; i < 60; i++) begin
      run_frac(($urandom % 2) ? "R3 random" : "R2 random",
               $urandom, 12'($urandom), 6'(($urandom % 63) + 1),
               3'(($urandom % 7) + 1), 3'(($urandom % 7) + 1), 24'($urandom),
               1'($urandom));
    end
    for (int i = 0; i < 60; i++) begin
      run_leg("R4 random", $urandom, 13'($urandom), 6'($urandom), 4'($urandom), 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule